// File: doc/BRIEF.md
# Erase Status Toggle Generator

This block builds the status byte that a flash-style memory returns on reads while an erase is pending, running, suspended, or interrupted by a program inside a suspend. A command sequencer supplies the current mode on a 3-bit code, together with a bitmap of the blocks selected for erase. Each read strobe carries the block index of the address being read. One cycle later the block answers with a status byte, or with a flag that tells the read path to return ordinary array data.

Software polls the byte to follow the operation. The erase-timer bit shows whether the window for adding blocks is still open. The main toggle bit flips on each status read while the controller is busy. The auxiliary toggle bit flips only on reads of blocks in the erase set. Software can therefore locate the blocks that are being erased, and it can tell a suspended erase from a running one. A suspend does not halt the toggles at once: they keep running for a set number of cycles after the sequencer enters the suspend mode.

Top module: `est_status_gen`

## Requirements
- R1: After reset `rsp_vld`, `rsp_stat` and `rsp_arr` are 0. Both toggle states are 0, so the first status read returns bit 6 = 0 and bit 2 = 0.
- R2: Mode code 0 (idle) makes a read return `rsp_arr` = 1 and `rsp_stat` = 0x00. Every cycle spent in mode 0 clears both toggle states to 0.
- R3: `rsp_vld` is 1 exactly in the cycle after a cycle in which `rd_stb` was 1. Each read gives exactly one response.
- R4: Status bit 3 (erase timer) reads 0 in mode 1 (timeout running). It reads 1 in mode 2 (erasing), mode 3 (suspended) and mode 4 (program in suspend). A status response has `rsp_arr` = 0.
- R5: In modes 1 and 2, bit 6 returns the main toggle state and that state then inverts. Successive reads therefore alternate. Cycles without a read leave it unchanged.
- R6: In modes 1 and 2, bit 2 returns the auxiliary toggle state. The state inverts only when the read addresses a block whose bit is set in `erase_set`. Reads of other blocks return it without changing it.
- R7: For the first SUSP_LAT cycles after entering mode 3, reads behave as in mode 2: both toggles run and bit 3 = 1. Re-entering mode 3 from any other mode restarts this count.
- R8: Once the suspend latency has elapsed in mode 3, a read of a block in the erase set returns bit 6 = 1 and bit 3 = 1. Bit 2 returns the auxiliary state, which then inverts. The main toggle state is left unchanged.
- R9: Once the suspend latency has elapsed in mode 3, a read of a block outside the erase set returns `rsp_arr` = 1 and `rsp_stat` = 0x00. Neither toggle state changes.
- R10: In mode 4 every read returns bit 3 = 1 and inverts both toggle states, whatever block it addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seq_mode | input | 3 | Sequencer mode: 0 idle, 1 timeout, 2 erasing, 3 suspended, 4 program in suspend |
| erase_set | input | NBLK | Bitmap of blocks selected for erase |
| rd_stb | input | 1 | Read strobe, one per read |
| rd_blk | input | BLK_W | Block index of the read address |
| rsp_vld | output | 1 | Response valid, one cycle after a read |
| rsp_stat | output | 8 | Status byte: bit 6 main toggle, bit 3 timer, bit 2 auxiliary toggle |
| rsp_arr | output | 1 | Return array data instead of status |

## Verification
The end of the suspend latency can coincide with a read. The bench issues a read on every cycle after entering mode 3. Across that run, reads on the last latency cycle must still show the main toggle flipping, and reads on the very next cycle must show bit 6 held at 1. A mode change and a read can also share an edge: the bench switches from mode 4 back to mode 3 with a read in that same cycle. That read is judged against a restarted latency count, and the preserved toggle states are checked on the reads that follow.

// File: rtl/est_pkg.sv
// Shared definitions for the erase status toggle generator.
// Assumes the sequencer drives one of the mode codes below; other codes
// are treated as plain array reads.
package est_pkg;

    typedef enum logic [2:0] {
        EM_IDLE  = 3'd0,
        EM_TMO   = 3'd1,
        EM_ERASE = 3'd2,
        EM_SUSP  = 3'd3,
        EM_SPROG = 3'd4
    } est_mode_e;

    // Bit positions decoded by polling software.
    localparam int unsigned BIT_MAIN = 6;
    localparam int unsigned BIT_TMR  = 3;
    localparam int unsigned BIT_AUX  = 2;

    typedef struct packed {
        logic clr;
        logic flip_aux;
        logic flip_main;
    } est_tgl_cmd_t;

endpackage

// File: rtl/est_susp_timer.sv
// Suspend latency timer: counts cycles spent in the suspended mode and
// reports when the toggle bits should stop. Assumes in_susp drops for at
// least one cycle between separate suspends, which restarts the count.
module est_susp_timer #(
    parameter int unsigned SUSP_LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_susp,
    output logic halted
);
    localparam int unsigned CW = (SUSP_LAT > 0) ? $clog2(SUSP_LAT + 1) : 1;
    localparam logic [CW-1:0] LAT_C = CW'(SUSP_LAT);

    logic [CW-1:0] cnt;

    // Count suspended cycles up to the latency limit, clear outside suspend.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!in_susp) begin
            cnt <= '0;
        end else if (cnt != LAT_C) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Halted once the count has reached the latency.
    always_comb halted = in_susp && (cnt == LAT_C);

endmodule

// File: rtl/est_toggle_pair.sv
// Holds the main and auxiliary toggle states. Each bit inverts when its
// flip request is set; clear wins over flip.
module est_toggle_pair
    import est_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  est_tgl_cmd_t cmd,
    output logic         t_main,
    output logic         t_aux
);
    logic [1:0] flip;
    logic [1:0] q;

    // Gather the flip requests into a vector indexed like q.
    always_comb flip = {cmd.flip_aux, cmd.flip_main};

    for (genvar i = 0; i < 2; i++) begin : g_tgl
        // One toggle flop: reset and clear to 0, else invert on request.
        always_ff @(posedge clk) begin
            if (!rst_n || cmd.clr) begin
                q[i] <= 1'b0;
            end else if (flip[i]) begin
                q[i] <= ~q[i];
            end
        end
    end

    // Present the two states on named outputs.
    always_comb begin
        t_main = q[0];
        t_aux  = q[1];
    end

endmodule

// File: rtl/est_resp_fmt.sv
// Combinational formatter: from mode, suspend halt, block membership and
// current toggle states, builds the status byte, the array-select flag and
// the toggle update for this cycle. Assumes rd is a single-cycle strobe.
module est_resp_fmt
    import est_pkg::*;
(
    input  est_mode_e    mode,
    input  logic         halted,
    input  logic         in_set,
    input  logic         rd,
    input  logic         t_main,
    input  logic         t_aux,
    output logic [7:0]   stat,
    output logic         arr_sel,
    output est_tgl_cmd_t cmd
);
    logic busy_erase;

    // Erase counts as running in timeout, erase, or within suspend latency.
    always_comb busy_erase = (mode == EM_TMO) || (mode == EM_ERASE) ||
                             ((mode == EM_SUSP) && !halted);

    // Select the response and toggle updates by effective mode.
    always_comb begin
        stat    = 8'h00;
        arr_sel = 1'b0;
        cmd     = '0;
        if (mode == EM_IDLE) begin
            arr_sel = 1'b1;
            cmd.clr = 1'b1;
        end else if (busy_erase) begin
            stat[BIT_MAIN] = t_main;
            stat[BIT_AUX]  = t_aux;
            stat[BIT_TMR]  = (mode != EM_TMO);
            cmd.flip_main  = rd;
            cmd.flip_aux   = rd && in_set;
        end else if (mode == EM_SUSP) begin
            if (in_set) begin
                stat[BIT_MAIN] = 1'b1;
                stat[BIT_AUX]  = t_aux;
                stat[BIT_TMR]  = 1'b1;
                cmd.flip_aux   = rd;
            end else begin
                arr_sel = 1'b1;
            end
        end else if (mode == EM_SPROG) begin
            stat[BIT_MAIN] = t_main;
            stat[BIT_AUX]  = t_aux;
            stat[BIT_TMR]  = 1'b1;
            cmd.flip_main  = rd;
            cmd.flip_aux   = rd;
        end else begin
            arr_sel = 1'b1;
        end
    end

endmodule

// File: rtl/est_status_gen.sv
// Erase status toggle generator top. Registers a status byte or an
// array-select flag one cycle after each read strobe. Assumes NBLK is a
// power of two so every rd_blk value names a block.
module est_status_gen
    import est_pkg::*;
#(
    parameter int unsigned NBLK     = 16,
    parameter int unsigned SUSP_LAT = 4,
    localparam int unsigned BLK_W   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       seq_mode,
    input  logic [NBLK-1:0]  erase_set,
    input  logic             rd_stb,
    input  logic [BLK_W-1:0] rd_blk,
    output logic             rsp_vld,
    output logic [7:0]       rsp_stat,
    output logic             rsp_arr
);
    est_mode_e    mode;
    logic         sus_halted;
    logic         blk_in_set;
    logic         t_main;
    logic         t_aux;
    logic [7:0]   fmt_stat;
    logic         fmt_arr;
    est_tgl_cmd_t tgl_cmd;

    // Decode the mode code and look up the addressed block.
    always_comb begin
        mode       = est_mode_e'(seq_mode);
        blk_in_set = erase_set[rd_blk];
    end

    est_susp_timer #(.SUSP_LAT(SUSP_LAT)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_susp(mode == EM_SUSP),
        .halted (sus_halted)
    );

    est_toggle_pair u_tgl (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (tgl_cmd),
        .t_main(t_main),
        .t_aux (t_aux)
    );

    est_resp_fmt u_fmt (
        .mode   (mode),
        .halted (sus_halted),
        .in_set (blk_in_set),
        .rd     (rd_stb),
        .t_main (t_main),
        .t_aux  (t_aux),
        .stat   (fmt_stat),
        .arr_sel(fmt_arr),
        .cmd    (tgl_cmd)
    );

    // Register the response for each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld  <= 1'b0;
            rsp_stat <= 8'h00;
            rsp_arr  <= 1'b0;
        end else begin
            rsp_vld <= rd_stb;
            if (rd_stb) begin
                rsp_stat <= fmt_stat;
                rsp_arr  <= fmt_arr;
            end
        end
    end

endmodule

// File: rtl/est_status_chk.sv
// Property checker for est_status_gen, attached by bind. Watches ports and
// the suspend-halt and block-membership signals of the top.
module est_status_chk #(
    parameter int unsigned NBLK  = 16,
    parameter int unsigned BLK_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       seq_mode,
    input logic             rd_stb,
    input logic             rsp_vld,
    input logic [7:0]       rsp_stat,
    input logic             rsp_arr,
    input logic             halted,
    input logic             in_set
);
    p_resp_follows_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rsp_vld);

    p_no_spurious_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> !rsp_vld);

    p_idle_array_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && seq_mode == 3'd0) |=> (rsp_arr && rsp_stat == 8'h00));

    p_timer_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && seq_mode == 3'd1) |=> (!rsp_stat[3] && !rsp_arr));

    p_timer_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && (seq_mode == 3'd2 || seq_mode == 3'd4)) |=> rsp_stat[3]);

    p_main_flips_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && seq_mode == 3'd2) ##1 (rd_stb && seq_mode == 3'd2)
        |=> (rsp_stat[6] != $past(rsp_stat[6])));

    p_latency_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && seq_mode == 3'd3 && !halted) |=> (!rsp_arr && rsp_stat[3]));

    p_halt_in_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && halted && in_set) |=> (rsp_stat[6] && rsp_stat[3] && !rsp_arr));

    p_halt_out_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && halted && !in_set) |=> (rsp_arr && rsp_stat == 8'h00));

    p_prog_both_flip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && seq_mode == 3'd4) ##1 (rd_stb && seq_mode == 3'd4)
        |=> (rsp_stat[6] != $past(rsp_stat[6]) && rsp_stat[2] != $past(rsp_stat[2])));

endmodule

bind est_status_gen est_status_chk #(.NBLK(NBLK), .BLK_W(BLK_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .seq_mode(seq_mode),
    .rd_stb  (rd_stb),
    .rsp_vld (rsp_vld),
    .rsp_stat(rsp_stat),
    .rsp_arr (rsp_arr),
    .halted  (sus_halted),
    .in_set  (blk_in_set)
);

// File: tb/est_status_gen_tb_top.sv
// Scoreboard bench: the driver task pushes one expected response per read,
// and a monitor pops and compares each response as it appears.
module est_status_gen_tb_top;
    localparam int unsigned CLK_P    = 10;
    localparam int unsigned NBLK     = 16;
    localparam int unsigned SUSP_LAT = 4;
    localparam int unsigned BLK_W    = 4;

    typedef struct {
        logic [8:0] v;
        string      tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       seq_mode = 3'd0;
    logic [NBLK-1:0]  erase_set = '0;
    logic             rd_stb = 1'b0;
    logic [BLK_W-1:0] rd_blk = '0;
    logic             rsp_vld;
    logic [7:0]       rsp_stat;
    logic             rsp_arr;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   n_rd = 0;
    int   n_rsp = 0;
    bit   mon_on = 1'b0;
    bit   done = 1'b0;

    logic m_main = 1'b0;
    logic m_aux = 1'b0;
    int   sus_k = 0;

    est_status_gen #(.NBLK(NBLK), .SUSP_LAT(SUSP_LAT)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .seq_mode (seq_mode),
        .erase_set(erase_set),
        .rd_stb   (rd_stb),
        .rd_blk   (rd_blk),
        .rsp_vld  (rsp_vld),
        .rsp_stat (rsp_stat),
        .rsp_arr  (rsp_arr)
    );

    always #(CLK_P / 2) clk = ~clk;

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got arr=%0b stat=%02h, want arr=%0b stat=%02h",
                     tag, act[8], act[7:0], exp[8], exp[7:0]);
        end
    endtask

    // Drive one cycle at the falling edge and predict its response.
    task automatic step(input logic [2:0] m, input logic rd, input int blk);
        logic [7:0] es;
        logic       ea;
        logic       halt;
        logic       ins;
        string      tag;
        @(negedge clk);
        seq_mode = m;
        rd_stb   = rd;
        rd_blk   = BLK_W'(blk);
        es = 8'h00;
        ea = 1'b0;
        halt = 1'b0;
        ins = erase_set[blk];
        if (m == 3'd3) begin
            halt = (sus_k >= SUSP_LAT);
            if (sus_k < SUSP_LAT) sus_k++;
        end else begin
            sus_k = 0;
        end
        if (m == 3'd0) begin
            tag = "R2";
            ea = 1'b1;
            m_main = 1'b0;
            m_aux = 1'b0;
        end else if (m == 3'd1 || m == 3'd2 || (m == 3'd3 && !halt)) begin
            tag = (m == 3'd3) ? "R7" : (ins ? "R4 R5 R6" : "R4 R5");
            es[6] = m_main;
            es[2] = m_aux;
            es[3] = (m != 3'd1);
            if (rd) begin
                m_main = ~m_main;
                if (ins) m_aux = ~m_aux;
            end
        end else if (m == 3'd3) begin
            if (ins) begin
                tag = "R8";
                es[6] = 1'b1;
                es[2] = m_aux;
                es[3] = 1'b1;
                if (rd) m_aux = ~m_aux;
            end else begin
                tag = "R9";
                ea = 1'b1;
            end
        end else begin
            tag = "R10";
            es[6] = m_main;
            es[2] = m_aux;
            es[3] = 1'b1;
            if (rd) begin
                m_main = ~m_main;
                m_aux = ~m_aux;
            end
        end
        if (rd) begin
            q.push_back('{v: {ea, es}, tag: tag});
            n_rd++;
        end
    endtask

    // Monitor: compare each response against the oldest expectation.
    always @(negedge clk) begin
        if (mon_on && rsp_vld) begin
            n_rsp++;
            if (q.size() == 0) begin
                n_chk++;
                n_bad++;
                $display("FAIL R3: got unexpected response, want none");
            end else begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, {rsp_arr, rsp_stat}, e.v);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got hang, want completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of the outputs.
        check("R1", {rsp_arr, rsp_stat}, 9'h000);
        n_chk++;
        if (rsp_vld !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: got rsp_vld=%0b, want 0", rsp_vld);
        end
        mon_on = 1'b1;
        erase_set = 16'h0024;   // blocks 2 and 5 selected
        // R1: first status read straight out of reset shows toggles at 0.
        step(3'd1, 1'b1, 2);
        step(3'd0, 1'b1, 2);
        step(3'd0, 1'b1, 9);
        step(3'd0, 1'b0, 0);
        // Timeout: R5 alternation, idle cycles between, R6 by block.
        step(3'd1, 1'b1, 2);
        step(3'd1, 1'b0, 0);
        step(3'd1, 1'b0, 0);
        step(3'd1, 1'b1, 3);
        step(3'd1, 1'b1, 2);
        step(3'd1, 1'b1, 3);
        // Erasing.
        step(3'd2, 1'b1, 5);
        step(3'd2, 1'b1, 0);
        step(3'd2, 1'b0, 0);
        step(3'd2, 1'b1, 5);
        step(3'd2, 1'b1, 5);
        // R2: idle clears toggles.
        step(3'd0, 1'b0, 0);
        step(3'd1, 1'b1, 2);
        step(3'd2, 1'b1, 2);
        // R7 latency boundary, then R8 and R9, reads every cycle.
        for (int i = 0; i < SUSP_LAT + 4; i++) begin
            step(3'd3, 1'b1, (i % 2 == 0) ? 2 : 7);
        end
        step(3'd3, 1'b1, 5);
        step(3'd3, 1'b1, 5);
        // R10: program inside suspend.
        step(3'd4, 1'b1, 7);
        step(3'd4, 1'b1, 2);
        step(3'd4, 1'b1, 7);
        // Re-entry to suspend with a read on the switching cycle.
        for (int i = 0; i < SUSP_LAT + 3; i++) begin
            step(3'd3, 1'b1, (i % 2 == 0) ? 7 : 5);
        end
        step(3'd0, 1'b1, 5);
        step(3'd0, 1'b0, 0);
        step(3'd0, 1'b0, 0);
        // R3: one response per read, none left over.
        n_chk++;
        if (n_rsp != n_rd || q.size() != 0) begin
            n_bad++;
            $display("FAIL R3: got %0d responses, want %0d", n_rsp, n_rd);
        end
        finish_run();
    end

endmodule